// File: doc/BRIEF.md
# Serial Receive Data and Status Flag Controller

This block sits between a serial receive shift register and the processor bus. When the deserializer signals that a character has been received, the block captures the byte into a data register and raises a data-full flag. If a second character arrives before the first has been collected, the block raises an overrun flag and throws away the new byte. The older byte stays in the data register.

While the overrun flag is up, the block stops reception. In synchronous mode it stops transmission as well. It does this through halt outputs that drive the deserializer and the transmitter.

Software reads the data register and a status word at two addresses. It drops a flag with a write-zero handshake: the flag must first be seen at 1 in a status read, and only then does a write of 0 to that bit clear it. A DMA read strobe also empties the data-full flag. Power-on or manual reset clears everything. A standby request clears both flags.

Top module: `rx_status_ctrl`

## Requirements
- R1: After reset the data-full flag, the overrun flag, both halt outputs and the data register are all 0.
- R2: A completion pulse with receive enable high, no error, and both flags at 0 loads the byte into the data register and sets the data-full flag on the next clock edge.
- R3: A completion that flags a framing or parity error while the data-full flag is 0 leaves the data register, the data-full flag and the overrun flag unchanged.
- R4: A completion accepted while the data-full flag is 1, with or without error, sets the overrun flag and discards the byte; the data register keeps the earlier byte.
- R5: While the overrun flag is 1, completion pulses change neither the data register nor the data-full flag. The receive halt output is 1. The transmit halt output is 1 only when the synchronous-mode input is also 1. Once the overrun flag is cleared, reception resumes.
- R6: The data-full flag is status bit 0 (address 1; address 0 is the data register). A status write with bit 0 at 0 clears it only if a status read saw the bit at 1 after the flag was set. A write of 1 to the bit has no effect.
- R7: The overrun flag is status bit 1 and follows the same read-1-then-write-0 rule. A write of 0 without the preceding read has no effect.
- R8: A DMA read strobe clears the data-full flag. A CPU read of the data register does not clear it.
- R9: A standby request clears both flags and releases both halt outputs on the next edge.
- R10: With receive enable at 0, completion pulses are ignored and no flag changes.
- R11: The permission to clear that a status read grants is used up by one write of 0. It is also lost when the flag clears by any other means or sets again. A later write of 0 then needs a new status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on/manual reset |
| standby_i | input | 1 | Standby or module-standby request, clears flags |
| rx_en_i | input | 1 | Receive enable |
| sync_mode_i | input | 1 | 1 selects synchronous mode (overrun also halts transmit) |
| rx_done_i | input | 1 | Reception-complete pulse from the shift register |
| rx_err_i | input | 1 | Framing or parity error for this completion |
| rx_byte_i | input | DW | Received byte from the shift register |
| cpu_sel_i | input | 1 | CPU access strobe |
| cpu_wr_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | 1 | 0 = data register, 1 = status word |
| cpu_wdata_i | input | DW | CPU write data |
| cpu_rdata_o | output | DW | CPU read data (combinational on address) |
| dma_rd_i | input | 1 | DMA read strobe of the data register |
| dma_data_o | output | DW | Data register contents for DMA |
| rxfull_o | output | 1 | Data-full flag |
| overrun_o | output | 1 | Overrun flag |
| halt_rx_o | output | 1 | Stop request to the deserializer |
| halt_tx_o | output | 1 | Stop request to the transmitter |

## Verification
The flags, the data register and the arm state are registered, so any strobe is first visible one clock edge later. The CPU read data and the halt outputs are combinational on the current state and the mode input, so they are valid in the same cycle. The bench drives every strobe just after a falling edge and removes it at the next falling edge. It then samples the registered results at that second falling edge, after exactly one rising edge. Status read data is sampled one time unit after the address is applied, before the rising edge that arms the flags.

// File: rtl/rx_status_ctrl.sv
module rx_status_ctrl #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          standby_i,
  input  logic          rx_en_i,
  input  logic          sync_mode_i,
  input  logic          rx_done_i,
  input  logic          rx_err_i,
  input  logic [DW-1:0] rx_byte_i,
  input  logic          cpu_sel_i,
  input  logic          cpu_wr_i,
  input  logic          cpu_addr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic [DW-1:0] cpu_rdata_o,
  input  logic          dma_rd_i,
  output logic [DW-1:0] dma_data_o,
  output logic          rxfull_o,
  output logic          overrun_o,
  output logic          halt_rx_o,
  output logic          halt_tx_o
);
  localparam int FULL_BIT = 0;
  localparam int OVR_BIT  = 1;

  logic [DW-1:0] data_q;
  logic full_q, ovr_q, arm_full_q, arm_ovr_q;
  logic full_d, ovr_d, arm_full_d, arm_ovr_d;
  logic [DW-1:0] status_w;
  logic unused_wdata;

  wire accept   = rx_done_i & rx_en_i & ~ovr_q;
  wire load     = accept & ~rx_err_i & ~full_q;
  wire ovr_set  = accept & full_q;
  wire st_rd    = cpu_sel_i & ~cpu_wr_i & cpu_addr_i;
  wire st_wr    = cpu_sel_i & cpu_wr_i & cpu_addr_i;
  wire full_wr0 = st_wr & ~cpu_wdata_i[FULL_BIT];
  wire ovr_wr0  = st_wr & ~cpu_wdata_i[OVR_BIT];
  wire full_clr = (full_wr0 & arm_full_q) | dma_rd_i;
  wire ovr_clr  = ovr_wr0 & arm_ovr_q;

  assign unused_wdata = ^cpu_wdata_i;

  assign full_d     = load | (full_q & ~full_clr);
  assign ovr_d      = ovr_set | (ovr_q & ~ovr_clr);
  assign arm_full_d = full_d & ~load &
                      ((arm_full_q & ~full_wr0) | (st_rd & full_q));
  assign arm_ovr_d  = ovr_d & ~ovr_set &
                      ((arm_ovr_q & ~ovr_wr0) | (st_rd & ovr_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q     <= 1'b0;
      ovr_q      <= 1'b0;
      arm_full_q <= 1'b0;
      arm_ovr_q  <= 1'b0;
    end else if (standby_i) begin
      full_q     <= 1'b0;
      ovr_q      <= 1'b0;
      arm_full_q <= 1'b0;
      arm_ovr_q  <= 1'b0;
    end else begin
      full_q     <= full_d;
      ovr_q      <= ovr_d;
      arm_full_q <= arm_full_d;
      arm_ovr_q  <= arm_ovr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 data_q <= '0;
    else if (load & ~standby_i) data_q <= rx_byte_i;
  end

  always_comb begin
    status_w           = '0;
    status_w[FULL_BIT] = full_q;
    status_w[OVR_BIT]  = ovr_q;
  end

  assign cpu_rdata_o = cpu_addr_i ? status_w : data_q;
  assign dma_data_o  = data_q;
  assign rxfull_o    = full_q;
  assign overrun_o   = ovr_q;
  assign halt_rx_o   = ovr_q;
  assign halt_tx_o   = ovr_q & sync_mode_i;
endmodule

// File: rtl/rx_status_ctrl_chk.sv
module rx_status_ctrl_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          standby_i,
  input logic          rx_en_i,
  input logic          sync_mode_i,
  input logic          rx_done_i,
  input logic          rx_err_i,
  input logic [DW-1:0] rx_byte_i,
  input logic          cpu_sel_i,
  input logic          cpu_wr_i,
  input logic          cpu_addr_i,
  input logic [DW-1:0] cpu_wdata_i,
  input logic          dma_rd_i,
  input logic [DW-1:0] dma_data_o,
  input logic          rxfull_o,
  input logic          overrun_o,
  input logic          halt_rx_o,
  input logic          halt_tx_o
);
  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done_i && rx_en_i && !rx_err_i && !rxfull_o && !overrun_o && !standby_i
    |=> rxfull_o && dma_data_o == $past(rx_byte_i));

  assert_overrun_keeps_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done_i && rx_en_i && rxfull_o && !overrun_o && !standby_i
    |=> overrun_o && $stable(dma_data_o));

  assert_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |=> $stable(dma_data_o));

  assert_halt_tx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    halt_tx_o |-> sync_mode_i && halt_rx_o && overrun_o);

  assert_write_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_sel_i && cpu_wr_i && cpu_addr_i && cpu_wdata_i[0] && rxfull_o &&
    !dma_rd_i && !standby_i |=> rxfull_o);

  assert_cpu_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_sel_i && !cpu_wr_i && !cpu_addr_i && rxfull_o && !dma_rd_i && !standby_i
    |=> rxfull_o);

  assert_standby_R9: assert property (@(posedge clk) disable iff (!rst_n)
    standby_i |=> !rxfull_o && !overrun_o && !halt_rx_o);

  assert_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en_i && !rxfull_o && !overrun_o |=> !rxfull_o && !overrun_o);
endmodule

bind rx_status_ctrl rx_status_ctrl_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .standby_i(standby_i), .rx_en_i(rx_en_i),
  .sync_mode_i(sync_mode_i), .rx_done_i(rx_done_i), .rx_err_i(rx_err_i),
  .rx_byte_i(rx_byte_i), .cpu_sel_i(cpu_sel_i), .cpu_wr_i(cpu_wr_i),
  .cpu_addr_i(cpu_addr_i), .cpu_wdata_i(cpu_wdata_i), .dma_rd_i(dma_rd_i),
  .dma_data_o(dma_data_o), .rxfull_o(rxfull_o), .overrun_o(overrun_o),
  .halt_rx_o(halt_rx_o), .halt_tx_o(halt_tx_o)
);

// File: tb/rx_status_ctrl_tb.sv
module rx_status_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic standby_i = 1'b0, rx_en_i = 1'b1, sync_mode_i = 1'b0;
  logic rx_done_i = 1'b0, rx_err_i = 1'b0;
  logic [DW-1:0] rx_byte_i = '0;
  logic cpu_sel_i = 1'b0, cpu_wr_i = 1'b0, cpu_addr_i = 1'b0;
  logic [DW-1:0] cpu_wdata_i = '0;
  logic [DW-1:0] cpu_rdata_o, dma_data_o;
  logic dma_rd_i = 1'b0;
  logic rxfull_o, overrun_o, halt_rx_o, halt_tx_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_status_ctrl #(.DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .standby_i(standby_i), .rx_en_i(rx_en_i),
    .sync_mode_i(sync_mode_i), .rx_done_i(rx_done_i), .rx_err_i(rx_err_i),
    .rx_byte_i(rx_byte_i), .cpu_sel_i(cpu_sel_i), .cpu_wr_i(cpu_wr_i),
    .cpu_addr_i(cpu_addr_i), .cpu_wdata_i(cpu_wdata_i), .cpu_rdata_o(cpu_rdata_o),
    .dma_rd_i(dma_rd_i), .dma_data_o(dma_data_o), .rxfull_o(rxfull_o),
    .overrun_o(overrun_o), .halt_rx_o(halt_rx_o), .halt_tx_o(halt_tx_o)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic complete(input logic [DW-1:0] b, input logic err);
    @(negedge clk); rx_done_i = 1'b1; rx_byte_i = b; rx_err_i = err;
    @(negedge clk); rx_done_i = 1'b0; rx_err_i = 1'b0;
  endtask

  task automatic cpu_read(input logic addr, output logic [DW-1:0] val);
    @(negedge clk); cpu_sel_i = 1'b1; cpu_wr_i = 1'b0; cpu_addr_i = addr;
    #1 val = cpu_rdata_o;
    @(negedge clk); cpu_sel_i = 1'b0;
  endtask

  task automatic status_write(input logic [DW-1:0] v);
    @(negedge clk); cpu_sel_i = 1'b1; cpu_wr_i = 1'b1; cpu_addr_i = 1'b1; cpu_wdata_i = v;
    @(negedge clk); cpu_sel_i = 1'b0; cpu_wr_i = 1'b0;
  endtask

  task automatic dma_read();
    @(negedge clk); dma_rd_i = 1'b1;
    @(negedge clk); dma_rd_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 full", rxfull_o, 0);
    check("R1 overrun", overrun_o, 0);
    check("R1 halts", {halt_rx_o, halt_tx_o}, 0);
    check("R1 data", dma_data_o, 0);
  endtask

  task automatic t_error_frame();
    complete(8'h3C, 1'b1);
    check("R3 full", rxfull_o, 0);
    check("R3 data", dma_data_o, 0);
    check("R3 overrun", overrun_o, 0);
  endtask

  task automatic t_receive();
    logic [DW-1:0] v;
    complete(8'hA5, 1'b0);
    check("R2 full", rxfull_o, 1);
    check("R2 data", dma_data_o, 8'hA5);
    cpu_read(1'b0, v);
    check("R8 cpu data", v, 8'hA5);
    check("R8 cpu read keeps full", rxfull_o, 1);
  endtask

  task automatic t_handshake();
    logic [DW-1:0] v;
    status_write(8'h00);
    check("R6 write0 without read", rxfull_o, 1);
    cpu_read(1'b1, v);
    check("R6 status read", v, 8'h01);
    status_write(8'h01);
    check("R6 write1 no effect", rxfull_o, 1);
    status_write(8'h00);
    check("R6 armed write0 clears", rxfull_o, 0);
    complete(8'h11, 1'b0);
    status_write(8'h00);
    check("R11 arm used up", rxfull_o, 1);
    cpu_read(1'b1, v);
    status_write(8'h00);
    check("R6 second clear", rxfull_o, 0);
  endtask

  task automatic t_dma();
    logic [DW-1:0] v;
    complete(8'h5A, 1'b0);
    check("R8 dma data", dma_data_o, 8'h5A);
    cpu_read(1'b1, v);
    dma_read();
    check("R8 dma clears", rxfull_o, 0);
    complete(8'h66, 1'b0);
    status_write(8'h00);
    check("R11 arm lost on dma clear", rxfull_o, 1);
    dma_read();
    check("R8 dma clears again", rxfull_o, 0);
  endtask

  task automatic t_overrun();
    logic [DW-1:0] v;
    complete(8'h21, 1'b0);
    complete(8'h42, 1'b0);
    check("R4 overrun", overrun_o, 1);
    check("R4 data kept", dma_data_o, 8'h21);
    check("R5 halt rx", halt_rx_o, 1);
    check("R5 halt tx async", halt_tx_o, 0);
    sync_mode_i = 1'b1; #1;
    check("R5 halt tx sync", halt_tx_o, 1);
    sync_mode_i = 1'b0;
    dma_read();
    complete(8'h99, 1'b0);
    check("R5 blocked full", rxfull_o, 0);
    check("R5 blocked data", dma_data_o, 8'h21);
    status_write(8'h00);
    check("R7 write0 without read", overrun_o, 1);
    cpu_read(1'b1, v);
    check("R7 status read", v, 8'h02);
    status_write(8'h00);
    check("R7 clear", overrun_o, 0);
    check("R5 halt released", halt_rx_o, 0);
    complete(8'h99, 1'b0);
    check("R5 resumed", dma_data_o, 8'h99);
    complete(8'h13, 1'b1);
    check("R4 error while full", overrun_o, 1);
    cpu_read(1'b1, v);
    status_write(8'h00);
    dma_read();
    check("R7 cleanup", {overrun_o, rxfull_o}, 0);
  endtask

  task automatic t_disabled();
    rx_en_i = 1'b0;
    complete(8'h12, 1'b0);
    check("R10 no load", rxfull_o, 0);
    check("R10 data", dma_data_o, 8'h99);
    rx_en_i = 1'b1;
    complete(8'h34, 1'b0);
    rx_en_i = 1'b0;
    complete(8'h56, 1'b0);
    check("R10 no overrun", overrun_o, 0);
    check("R10 data kept", dma_data_o, 8'h34);
    rx_en_i = 1'b1;
  endtask

  task automatic t_standby();
    complete(8'h78, 1'b0);
    check("R9 overrun before", overrun_o, 1);
    @(negedge clk); standby_i = 1'b1;
    @(negedge clk); standby_i = 1'b0;
    check("R9 flags", {overrun_o, rxfull_o}, 0);
    check("R9 halt", halt_rx_o, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_error_frame();
    t_receive();
    t_handshake();
    t_dma();
    t_overrun();
    t_disabled();
    t_standby();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule